// File: doc/BRIEF.md
# Wake Clock Switchover Controller

This controller picks the clock source that drives the system after it leaves stop mode. In stop mode the crystal is switched off. When a wake event arrives, software may choose to run at once from a fast internal ring oscillator. In that case a warm-up counter counts crystal clock enables until the crystal is stable. The controller then moves the system clock over to the crystal and turns the ring off. If the ring is not chosen, the processor stays held until the same warm-up count has finished.

While the ring is the source, the controller forces the clock-divide setting to the divide-by-1 code. It discards any software write to the divide bits in that time. A status output shows whether the ring is currently driving the system. The watchdog tick is always taken from the crystal. The oscillators and the glitch-free clock multiplexer sit outside this block, and every clock is modelled here as an enable.

Top module: `wake_clk_switch`

## Requirements
- R1: After reset the block runs from the crystal with these outputs: xtalOn=1, ringOn=0, clkSelXtal=1, cpuRun=1, ringActive=0, divEff=2'b10.
- R2: A stopReq sampled while the crystal is on makes xtalOn, ringOn and cpuRun all 0 from the next cycle.
- R3: A wakeEvt sampled in stop with ringSelEn=1 gives these outputs from the next cycle: xtalOn=1, ringOn=1, clkSelXtal=0, cpuRun=1, ringActive=1.
- R4: A wakeEvt sampled in stop with ringSelEn=0 gives xtalOn=1, ringOn=0 and cpuRun=0 until warm-up completes, and ringActive stays 0 during that time.
- R5: Warm-up ends on the clock edge that samples the 2^WARM_W-th xtalTick pulse after wake; cycles with xtalTick=0 do not count. In the next cycle the outputs are clkSelXtal=1, ringOn=0, cpuRun=1 and ringActive=0. The default WARM_W of 16 gives 65,536 ticks.
- R6: While ringActive=1, divEff reads the divide-by-1 code 2'b10, whatever value is stored.
- R7: A divide write (divWrEn with divWrData) lands in divEff in the next cycle when ringActive=0. When ringActive=1 the write is thrown away, and after switchover divEff shows the value stored before the ring period.
- R8: A stopReq during warm-up sends the block back to stop and clears the count, so the next wake needs a full 2^WARM_W ticks again.
- R9: wdtTick equals xtalTick in the same cycle while xtalOn=1, and is 0 while xtalOn=0. The ring state does not affect it.
- R10: wakeEvt has no effect unless the block is in stop, and stopReq has no effect while the block is already in stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| xtalTick | input | 1 | Crystal clock enable, one pulse per crystal period |
| stopReq | input | 1 | Request to enter stop mode |
| wakeEvt | input | 1 | Wake event that ends stop mode |
| ringSelEn | input | 1 | Use the ring clock during warm-up, sampled at wake |
| divWrEn | input | 1 | Divide-bit write strobe |
| divWrData | input | 2 | Divide-bit write value |
| xtalOn | output | 1 | Crystal oscillator enable |
| ringOn | output | 1 | Ring oscillator enable |
| clkSelXtal | output | 1 | System clock select, 1 = crystal, 0 = ring |
| cpuRun | output | 1 | Processor may execute |
| ringActive | output | 1 | Status: ring is the system clock |
| divEff | output | 2 | Effective clock-divide bits |
| wdtTick | output | 1 | Watchdog tick from the crystal |

## Verification
Every state-driven output (xtalOn, ringOn, clkSelXtal, cpuRun, ringActive, divEff) changes one cycle after the edge that samples a stopReq, wakeEvt or accepted divide write. The switchover shows in the cycle after the edge that samples the final counted tick, so with ticks on every cycle starting from the wake edge, the ring state is still visible 2^WARM_W-1 cycles after wake and the crystal state at 2^WARM_W. wdtTick is combinational and is checked in the same cycle its input is driven. The bench stores each expected value together with the cycle number in which it falls due, and compares it on the falling edge of that cycle.

// File: rtl/wake_clk_pkg.sv
package wake_clk_pkg;
  typedef enum logic [1:0] {
    ST_XTAL = 2'd0,
    ST_STOP = 2'd1,
    ST_RING = 2'd2,
    ST_HOLD = 2'd3
  } wakeState_t;

  typedef struct packed {
    logic cntClr;
    logic cntRun;
    logic ringSet;
    logic ringClr;
  } dpStrobe_t;

  localparam logic [1:0] DIV_BY_ONE = 2'b10;
endpackage

// File: rtl/wake_clk_ctrl.sv
module wake_clk_ctrl
  import wake_clk_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      stopReq,
  input  logic      wakeEvt,
  input  logic      ringSelEn,
  input  logic      warmDone,
  output dpStrobe_t strobe,
  output logic      xtalOn,
  output logic      ringOn,
  output logic      clkSelXtal,
  output logic      cpuRun
);
  wakeState_t state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_XTAL: if (stopReq) nextState = ST_STOP;
      ST_STOP: if (wakeEvt) nextState = ringSelEn ? ST_RING : ST_HOLD;
      ST_RING,
      ST_HOLD: begin
        if (stopReq)       nextState = ST_STOP;
        else if (warmDone) nextState = ST_XTAL;
      end
      default: nextState = ST_XTAL;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_XTAL;
    else       state <= nextState;
  end

  always_comb begin
    strobe.cntClr  = (nextState == ST_STOP) && (state != ST_STOP);
    strobe.cntRun  = (state == ST_RING) || (state == ST_HOLD);
    strobe.ringSet = (state == ST_STOP) && wakeEvt && ringSelEn;
    strobe.ringClr = (state == ST_RING) && (stopReq || warmDone);
  end

  assign xtalOn     = (state != ST_STOP);
  assign ringOn     = (state == ST_RING);
  assign clkSelXtal = (state != ST_RING);
  assign cpuRun     = (state == ST_XTAL) || (state == ST_RING);
endmodule

// File: rtl/wake_clk_dp.sv
module wake_clk_dp
  import wake_clk_pkg::*;
#(
  parameter int         WARM_W    = 16,
  parameter logic [1:0] DIV_RESET = 2'b10
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strobe,
  input  logic       xtalTick,
  input  logic       xtalOn,
  input  logic       divWrEn,
  input  logic [1:0] divWrData,
  output logic       warmDone,
  output logic       ringActive,
  output logic [1:0] divEff,
  output logic       wdtTick
);
  localparam logic [WARM_W-1:0] CNT_LAST = {WARM_W{1'b1}};

  logic [WARM_W-1:0] warmCnt;
  logic [1:0]        divReg;
  logic              cntStep;

  assign cntStep  = strobe.cntRun && xtalTick;
  assign warmDone = cntStep && (warmCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             warmCnt <= '0;
    else if (strobe.cntClr) warmCnt <= '0;
    else if (cntStep)       warmCnt <= warmCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               ringActive <= 1'b0;
    else if (strobe.ringSet) ringActive <= 1'b1;
    else if (strobe.ringClr) ringActive <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        divReg <= DIV_RESET;
    else if (divWrEn && !ringActive)  divReg <= divWrData;
  end

  assign divEff  = ringActive ? DIV_BY_ONE : divReg;
  assign wdtTick = xtalOn && xtalTick;
endmodule

// File: rtl/wake_clk_switch.sv
module wake_clk_switch
  import wake_clk_pkg::*;
#(
  parameter int WARM_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       xtalTick,
  input  logic       stopReq,
  input  logic       wakeEvt,
  input  logic       ringSelEn,
  input  logic       divWrEn,
  input  logic [1:0] divWrData,
  output logic       xtalOn,
  output logic       ringOn,
  output logic       clkSelXtal,
  output logic       cpuRun,
  output logic       ringActive,
  output logic [1:0] divEff,
  output logic       wdtTick
);
  dpStrobe_t strobe;
  logic      warmDone;

  wake_clk_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .stopReq    (stopReq),
    .wakeEvt    (wakeEvt),
    .ringSelEn  (ringSelEn),
    .warmDone   (warmDone),
    .strobe     (strobe),
    .xtalOn     (xtalOn),
    .ringOn     (ringOn),
    .clkSelXtal (clkSelXtal),
    .cpuRun     (cpuRun)
  );

  wake_clk_dp #(.WARM_W(WARM_W), .DIV_RESET(DIV_BY_ONE)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .xtalTick   (xtalTick),
    .xtalOn     (xtalOn),
    .divWrEn    (divWrEn),
    .divWrData  (divWrData),
    .warmDone   (warmDone),
    .ringActive (ringActive),
    .divEff     (divEff),
    .wdtTick    (wdtTick)
  );
endmodule

// File: rtl/wake_clk_checker.sv
module wake_clk_checker (
  input logic       clk,
  input logic       rstN,
  input logic       xtalTick,
  input logic       stopReq,
  input logic       wakeEvt,
  input logic       ringSelEn,
  input logic       divWrEn,
  input logic [1:0] divWrData,
  input logic       xtalOn,
  input logic       ringOn,
  input logic       clkSelXtal,
  input logic       cpuRun,
  input logic       ringActive,
  input logic [1:0] divEff,
  input logic       wdtTick
);
  p_stop_cuts_xtal_r2: assert property (@(posedge clk) disable iff (!rstN)
    (xtalOn && stopReq) |=> (!xtalOn && !ringOn && !cpuRun));

  p_ring_wake_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!xtalOn && wakeEvt && ringSelEn) |=> (ringOn && ringActive && cpuRun && !clkSelXtal));

  p_status_tracks_ring_r3: assert property (@(posedge clk) disable iff (!rstN)
    ringOn == ringActive);

  p_hold_no_ring_r4: assert property (@(posedge clk) disable iff (!rstN)
    (xtalOn && !cpuRun) |-> (!ringOn && !ringActive));

  p_switch_to_xtal_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ringActive) |-> (clkSelXtal && (cpuRun || !xtalOn)));

  p_div_forced_r6: assert property (@(posedge clk) disable iff (!rstN)
    ringOn |-> (divEff == 2'b10));

  p_div_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!ringActive && divWrEn && !wakeEvt) |=> (divEff == $past(divWrData)));

  p_wdt_from_xtal_r9: assert property (@(posedge clk) disable iff (!rstN)
    !xtalOn |-> !wdtTick);
endmodule

bind wake_clk_switch wake_clk_checker u_chk (.*);

// File: tb/wake_clk_switch_bench.sv
module wake_clk_switch_bench;
  localparam int W     = 8;
  localparam int TICKS = 1 << W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic xtalTick = 1'b1, stopReq = 1'b0, wakeEvt = 1'b0, ringSelEn = 1'b0, divWrEn = 1'b0;
  logic [1:0] divWrData = 2'b00;
  logic xtalOn, ringOn, clkSelXtal, cpuRun, ringActive, wdtTick;
  logic [1:0] divEff;

  always #5 clk = ~clk;

  wake_clk_switch #(.WARM_W(W)) u_wake_clk_switch (
    .clk(clk), .rstN(rstN), .xtalTick(xtalTick), .stopReq(stopReq), .wakeEvt(wakeEvt),
    .ringSelEn(ringSelEn), .divWrEn(divWrEn), .divWrData(divWrData), .xtalOn(xtalOn),
    .ringOn(ringOn), .clkSelXtal(clkSelXtal), .cpuRun(cpuRun), .ringActive(ringActive),
    .divEff(divEff), .wdtTick(wdtTick)
  );

  typedef struct {
    int         due;
    logic [7:0] exp;
    string      req;
  } expItem_t;

  expItem_t sbQ[$];
  int cyc = 0;
  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // packing: {xtalOn, ringOn, clkSelXtal, cpuRun, ringActive, divEff[1:0], wdtTick}
  function automatic logic [7:0] mk(logic x, logic r, logic c, logic run, logic ra,
                                    logic [1:0] d, logic w);
    return {x, r, c, run, ra, d, w};
  endfunction

  task automatic expectAt(int due, logic [7:0] e, string req);
    expItem_t it;
    it.due = due; it.exp = e; it.req = req;
    sbQ.push_back(it);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic waitUntil(int c);
    while (cyc < c) step();
  endtask

  // monitor: compare every item that falls due in this cycle
  always @(negedge clk) begin
    logic [7:0] obs;
    obs = {xtalOn, ringOn, clkSelXtal, cpuRun, ringActive, divEff, wdtTick};
    for (int i = sbQ.size() - 1; i >= 0; i--) begin
      if (sbQ[i].due == cyc) begin
        nRun++;
        if (obs !== sbQ[i].exp) begin
          nFail++;
          $display("FAIL %s cycle %0d: actual %b expected %b", sbQ[i].req, cyc, obs, sbQ[i].exp);
        end
        sbQ.delete(i);
      end
    end
  end

  initial begin
    #1_500_000;
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    int wakeC;
    int tickOn;
    repeat (3) step();
    rstN = 1'b1;
    step();
    // R1 reset state
    expectAt(cyc, mk(1, 0, 1, 1, 0, 2'b10, 1), "R1");
    step();

    // R7 write accepted while on crystal
    divWrEn = 1'b1; divWrData = 2'b01;
    expectAt(cyc + 1, mk(1, 0, 1, 1, 0, 2'b01, 1), "R7");
    step(); divWrEn = 1'b0;

    // R2 enter stop
    stopReq = 1'b1;
    expectAt(cyc + 1, mk(0, 0, 1, 0, 0, 2'b01, 0), "R2");
    step();
    // R10 stopReq while stopped ignored; R9 wdt silent in stop with tick high
    expectAt(cyc + 1, mk(0, 0, 1, 0, 0, 2'b01, 0), "R10_R9");
    step(); stopReq = 1'b0;
    step();

    // R3 wake on ring
    wakeEvt = 1'b1; ringSelEn = 1'b1;
    wakeC = cyc + 1;
    expectAt(wakeC, mk(1, 1, 0, 1, 1, 2'b10, 1), "R3_R6");
    step(); wakeEvt = 1'b0; ringSelEn = 1'b0;
    // R7 write during ring discarded
    divWrEn = 1'b1; divWrData = 2'b11;
    expectAt(cyc + 1, mk(1, 1, 0, 1, 1, 2'b10, 1), "R7_R6");
    step(); divWrEn = 1'b0;
    // R10 wake while running on ring ignored
    wakeEvt = 1'b1;
    expectAt(cyc + 1, mk(1, 1, 0, 1, 1, 2'b10, 1), "R10");
    step(); wakeEvt = 1'b0;
    // R5 switchover timing, R7 old value restored
    expectAt(wakeC + TICKS - 1, mk(1, 1, 0, 1, 1, 2'b10, 1), "R5");
    expectAt(wakeC + TICKS, mk(1, 0, 1, 1, 0, 2'b01, 1), "R5_R7");
    waitUntil(wakeC + TICKS + 1);

    // R4 wake without ring, ticks paused for a while
    stopReq = 1'b1; step(); stopReq = 1'b0; step();
    wakeEvt = 1'b1; ringSelEn = 1'b0; xtalTick = 1'b0;
    expectAt(cyc + 1, mk(1, 0, 1, 0, 0, 2'b01, 0), "R4_R9");
    step(); wakeEvt = 1'b0;
    // R7 write accepted during hold
    divWrEn = 1'b1; divWrData = 2'b00;
    expectAt(cyc + 1, mk(1, 0, 1, 0, 0, 2'b00, 0), "R7");
    step(); divWrEn = 1'b0;
    repeat (100) step();
    expectAt(cyc, mk(1, 0, 1, 0, 0, 2'b00, 0), "R5_R4");
    step();
    xtalTick = 1'b1;
    expectAt(cyc, mk(1, 0, 1, 0, 0, 2'b00, 1), "R9");
    tickOn = cyc;
    expectAt(tickOn + TICKS - 1, mk(1, 0, 1, 0, 0, 2'b00, 1), "R5");
    expectAt(tickOn + TICKS, mk(1, 0, 1, 1, 0, 2'b00, 1), "R5");
    waitUntil(tickOn + TICKS + 1);

    // R8 stop during warm-up restarts the count
    stopReq = 1'b1; step(); stopReq = 1'b0; step();
    wakeEvt = 1'b1; ringSelEn = 1'b1;
    step(); wakeEvt = 1'b0; ringSelEn = 1'b0;
    repeat (100) step();
    stopReq = 1'b1;
    expectAt(cyc + 1, mk(0, 0, 1, 0, 0, 2'b00, 0), "R8");
    step(); stopReq = 1'b0;
    step();
    wakeEvt = 1'b1; ringSelEn = 1'b1;
    wakeC = cyc + 1;
    step(); wakeEvt = 1'b0; ringSelEn = 1'b0;
    expectAt(wakeC + TICKS - 1, mk(1, 1, 0, 1, 1, 2'b10, 1), "R8");
    expectAt(wakeC + TICKS, mk(1, 0, 1, 1, 0, 2'b00, 1), "R8");
    waitUntil(wakeC + TICKS + 2);

    if (sbQ.size() != 0) begin
      nRun++; nFail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sbQ.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule